// File: doc/BRIEF.md
# XGMII Loopback Router

This block sits on a 10-gigabit XGMII connection between a MAC and a PHY and decides where each stream goes. In the normal route, the MAC transmit stream goes out to the PHY and the PHY receive stream comes back to the MAC. In the local loopback route, the MAC transmit stream is still sent to the PHY, and a copy of it is also returned on the MAC receive side. While local loopback is on, anything the PHY delivers is dropped.

Software selects the route by writing a mode register through a small memory-mapped port. A write only records the requested mode. The block applies it at a frame boundary, when neither the MAC transmit stream nor the PHY receive stream is inside a frame and no frame starts in that cycle. This means no frame is ever cut short or joined to part of another. Every routed path passes through exactly one register stage.

Top module: `xlb_switch`

## Requirements
- R1: After reset both registered outputs carry the idle word: byte 0x07 on every lane with every control bit set. The mode register reads 0 (normal).
- R2: In normal mode (mode value 0), the MAC receive outputs equal the PHY receive inputs one clock cycle later.
- R3: In local loopback mode (mode value 1), the MAC receive outputs equal the MAC transmit inputs one clock cycle later.
- R4: In every mode, the PHY transmit outputs equal the MAC transmit inputs one clock cycle later.
- R5: In local loopback mode, frames arriving on the PHY receive inputs never appear on the MAC receive outputs.
- R6: A read of the mode register (address 0, value in bits 1:0) returns the mode currently in force, not a requested mode that is still waiting.
- R7: A requested mode change waits while the MAC transmit stream is inside a frame. A frame starts with byte 0xFB on lane 0 (bits 7:0) with control bit 0 set. It ends in the cycle that has byte 0xFD with the control bit set on any lane. That frame finishes on its old route.
- R8: A write to address 0 whose value is neither 0 nor 1 is ignored. The mode in force stays the same.
- R9: A write to any address other than 0 is ignored, and reads of such addresses return 0.
- R10: A requested mode change also waits while the PHY receive stream is inside a frame. This holds even while that stream is being discarded.
- R11: A mode change never takes effect in a cycle where a frame start appears on either input stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all paths |
| rstN | input | 1 | Synchronous reset, active low |
| macTxData | input | 64 | XGMII transmit data from the MAC |
| macTxCtrl | input | 8 | XGMII transmit control bits from the MAC, one per lane |
| phyTxData | output | 64 | XGMII transmit data to the PHY |
| phyTxCtrl | output | 8 | XGMII transmit control bits to the PHY |
| phyRxData | input | 64 | XGMII receive data from the PHY |
| phyRxCtrl | input | 8 | XGMII receive control bits from the PHY |
| macRxData | output | 64 | XGMII receive data to the MAC |
| macRxCtrl | output | 8 | XGMII receive control bits to the MAC |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr, combinational |

## Verification
The bench sweeps arithmetic data and control patterns through both routes. A design with the wrong stage count or a swapped mux would show the wrong word on the MAC receive side. It requests mode changes while a frame is open on the MAC side and on the PHY side, and in the very cycle a frame starts. A design that switched early would splice a frame, and the bench catches this as a mid-frame change in the receive source or in the read-back mode. It also sends out-of-range values and writes to other addresses, which a loose decoder would accept as a mode change. Finally, it sends a PHY frame during loopback, which a leaky mux would pass to the MAC.

// File: rtl/xlb_pkg.sv
package xlb_pkg;

  localparam logic [7:0] IDLE_CH  = 8'h07;
  localparam logic [7:0] START_CH = 8'hFB;
  localparam logic [7:0] TERM_CH  = 8'hFD;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_LOCAL  = 2'd1
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loopSel;    // route MAC transmit back to MAC receive this cycle
    logic switchNow;  // a pending mode is being applied this cycle
  } routeCtl_t;

endpackage

// File: rtl/xlb_frame_track.sv
module xlb_frame_track #(
  parameter int LANES = 8,
  localparam int DATA_W = LANES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] data,
  input  logic [LANES-1:0]  ctrl,
  output logic              startNow,
  output logic              busy
);
  import xlb_pkg::*;

  logic [LANES-1:0] laneTerm;
  logic             termNow;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign laneTerm[l] = ctrl[l] && (data[l*8 +: 8] == TERM_CH);
    end
  endgenerate

  assign termNow  = |laneTerm;
  assign startNow = ctrl[0] && (data[7:0] == START_CH);

  always_ff @(posedge clk) begin
    if (!rstN)         busy <= 1'b0;
    else if (startNow) busy <= 1'b1;
    else if (termNow)  busy <= 1'b0;
  end

  // a frame opened this cycle must be marked busy next cycle
  assert_start_opens_R7: assert property (@(posedge clk) disable iff (!rstN)
    startNow |=> busy);

endmodule

// File: rtl/xlb_ctrl.sv
module xlb_ctrl #(
  parameter int ADDR_W    = 4,
  parameter int REG_W     = 32,
  parameter int MODE_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              txBusy,
  input  logic              txStart,
  input  logic              rxBusy,
  input  logic              rxStart,
  output xlb_pkg::routeCtl_t routeCtl
);
  import xlb_pkg::*;

  localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);

  mode_e pendingMode, activeMode, effMode;
  logic  addrHit, wrLegal, quiet, switchNow;

  assign addrHit = (regAddr == MODE_A);
  assign wrLegal = regWr && addrHit &&
                   ((regWrData == REG_W'(MODE_NORMAL)) ||
                    (regWrData == REG_W'(MODE_LOCAL)));

  assign quiet     = !txBusy && !rxBusy && !txStart && !rxStart;
  assign switchNow = (pendingMode != activeMode) && quiet;
  assign effMode   = switchNow ? pendingMode : activeMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingMode <= MODE_NORMAL;
      activeMode  <= MODE_NORMAL;
    end else begin
      if (wrLegal) pendingMode <= mode_e'(regWrData[1:0]);
      activeMode <= effMode;
    end
  end

  assign regRdData          = addrHit ? REG_W'(activeMode) : '0;
  assign routeCtl.loopSel   = (effMode == MODE_LOCAL);
  assign routeCtl.switchNow = switchNow;

  assert_hold_tx_frame_R7: assert property (@(posedge clk) disable iff (!rstN)
    txBusy |=> $stable(activeMode));

  assert_hold_rx_frame_R10: assert property (@(posedge clk) disable iff (!rstN)
    rxBusy |=> $stable(activeMode));

  assert_no_switch_on_start_R11: assert property (@(posedge clk) disable iff (!rstN)
    (txStart || rxStart) |=> $stable(activeMode));

  always_comb begin
    if (rstN) begin
      assert_legal_mode_R8: assert (activeMode == MODE_NORMAL || activeMode == MODE_LOCAL);
    end
  end

endmodule

// File: rtl/xlb_datapath.sv
module xlb_datapath #(
  parameter int LANES = 8,
  localparam int DATA_W = LANES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlb_pkg::routeCtl_t routeCtl,
  input  logic [DATA_W-1:0] macTxData,
  input  logic [LANES-1:0]  macTxCtrl,
  input  logic [DATA_W-1:0] phyRxData,
  input  logic [LANES-1:0]  phyRxCtrl,
  output logic [DATA_W-1:0] phyTxData,
  output logic [LANES-1:0]  phyTxCtrl,
  output logic [DATA_W-1:0] macRxData,
  output logic [LANES-1:0]  macRxCtrl
);
  import xlb_pkg::*;

  localparam logic [DATA_W-1:0] IDLE_WORD = {LANES{IDLE_CH}};
  localparam logic [LANES-1:0]  IDLE_CTRL = {LANES{1'b1}};

  logic [DATA_W-1:0] rxSelData;
  logic [LANES-1:0]  rxSelCtrl;

  assign rxSelData = routeCtl.loopSel ? macTxData : phyRxData;
  assign rxSelCtrl = routeCtl.loopSel ? macTxCtrl : phyRxCtrl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phyTxData <= IDLE_WORD;
      phyTxCtrl <= IDLE_CTRL;
      macRxData <= IDLE_WORD;
      macRxCtrl <= IDLE_CTRL;
    end else begin
      phyTxData <= macTxData;
      phyTxCtrl <= macTxCtrl;
      macRxData <= rxSelData;
      macRxCtrl <= rxSelCtrl;
    end
  end

  assert_normal_route_R2: assert property (@(posedge clk) disable iff (!rstN)
    !routeCtl.loopSel |=> (macRxData == $past(phyRxData)) && (macRxCtrl == $past(phyRxCtrl)));

  assert_loop_route_R3: assert property (@(posedge clk) disable iff (!rstN)
    routeCtl.loopSel |=> (macRxData == $past(macTxData)) && (macRxCtrl == $past(macTxCtrl)));

  assert_tx_copy_R4: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (phyTxData == $past(macTxData)) && (phyTxCtrl == $past(macTxCtrl)));

endmodule

// File: rtl/xlb_switch.sv
module xlb_switch #(
  parameter int LANES     = 8,
  parameter int ADDR_W    = 4,
  parameter int REG_W     = 32,
  parameter int MODE_ADDR = 0,
  localparam int DATA_W   = LANES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] macTxData,
  input  logic [LANES-1:0]  macTxCtrl,
  output logic [DATA_W-1:0] phyTxData,
  output logic [LANES-1:0]  phyTxCtrl,
  input  logic [DATA_W-1:0] phyRxData,
  input  logic [LANES-1:0]  phyRxCtrl,
  output logic [DATA_W-1:0] macRxData,
  output logic [LANES-1:0]  macRxCtrl,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData
);
  import xlb_pkg::*;

  routeCtl_t routeCtl;
  logic txBusy, txStart, rxBusy, rxStart;

  xlb_frame_track #(.LANES(LANES)) u_txTrack (
    .clk(clk), .rstN(rstN), .data(macTxData), .ctrl(macTxCtrl),
    .startNow(txStart), .busy(txBusy));

  xlb_frame_track #(.LANES(LANES)) u_rxTrack (
    .clk(clk), .rstN(rstN), .data(phyRxData), .ctrl(phyRxCtrl),
    .startNow(rxStart), .busy(rxBusy));

  xlb_ctrl #(.ADDR_W(ADDR_W), .REG_W(REG_W), .MODE_ADDR(MODE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .txBusy(txBusy), .txStart(txStart), .rxBusy(rxBusy), .rxStart(rxStart),
    .routeCtl(routeCtl));

  xlb_datapath #(.LANES(LANES)) u_dp (
    .clk(clk), .rstN(rstN), .routeCtl(routeCtl),
    .macTxData(macTxData), .macTxCtrl(macTxCtrl),
    .phyRxData(phyRxData), .phyRxCtrl(phyRxCtrl),
    .phyTxData(phyTxData), .phyTxCtrl(phyTxCtrl),
    .macRxData(macRxData), .macRxCtrl(macRxCtrl));

endmodule

// File: tb/sim_xlb_switch.sv
`timescale 1ns/1ps
module sim_xlb_switch;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] macTxData, phyRxData, phyTxData, macRxData;
  logic [7:0]  macTxCtrl, phyRxCtrl, phyTxCtrl, macRxCtrl;
  logic        regWr = 1'b0;
  logic [3:0]  regAddr = 4'd0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [63:0] IDLE_D  = {8{8'h07}};
  localparam logic [63:0] START_D = {{7{8'h55}}, 8'hFB};
  localparam logic [63:0] TERM_D  = {{7{8'h07}}, 8'hFD};

  always #5 clk = ~clk;

  xlb_switch u0 (
    .clk(clk), .rstN(rstN),
    .macTxData(macTxData), .macTxCtrl(macTxCtrl),
    .phyTxData(phyTxData), .phyTxCtrl(phyTxCtrl),
    .phyRxData(phyRxData), .phyRxCtrl(phyRxCtrl),
    .macRxData(macRxData), .macRxCtrl(macRxCtrl),
    .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData));

  // payload bytes stay below 0x80, so never a start or terminate character
  function automatic logic [63:0] pat(int i, int seed);
    logic [63:0] w;
    for (int l = 0; l < 8; l++) w[l*8 +: 8] = 8'((i * seed + l * 13 + seed) & 8'h7F);
    return w;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [71:0] act, logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic setTx(logic [63:0] d, logic [7:0] c); macTxData = d; macTxCtrl = c; endtask
  task automatic setRx(logic [63:0] d, logic [7:0] c); phyRxData = d; phyRxCtrl = c; endtask

  task automatic readMode(string req, logic [31:0] exp);
    regAddr = 4'd0; #1;
    chk(req, {40'd0, regRdData}, {40'd0, exp});
  endtask

  task automatic macRxIs(string req, logic [63:0] d, logic [7:0] c);
    chk(req, {macRxCtrl, macRxData}, {c, d});
  endtask

  task automatic putWrite(logic [3:0] a, logic [31:0] v);
    regWr = 1'b1; regAddr = a; regWrData = v;
  endtask

  task automatic stopWrite();
    regWr = 1'b0; regAddr = 4'd0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    setTx(IDLE_D, 8'hFF); setRx(IDLE_D, 8'hFF);
    repeat (3) tick();
    // R1 reset state
    chk("R1 phyTx", {phyTxCtrl, phyTxData}, {8'hFF, IDLE_D});
    macRxIs("R1 macRx", IDLE_D, 8'hFF);
    readMode("R1 mode", 32'd0);
    rstN = 1'b1;

    // R2/R4 normal sweep
    for (int i = 0; i < 128; i++) begin
      setTx(pat(i, 37), 8'(i)); setRx(pat(i, 53), 8'(i * 3));
      tick();
      macRxIs("R2 normal", pat(i, 53), 8'(i * 3));
      chk("R4 normal", {phyTxCtrl, phyTxData}, {8'(i), pat(i, 37)});
    end

    // enter local loopback
    setTx(IDLE_D, 8'hFF); setRx(IDLE_D, 8'hFF);
    putWrite(4'd0, 32'd1); tick(); stopWrite();
    readMode("R6 pending only", 32'd0);
    tick();
    readMode("R6 active", 32'd1);

    // R3/R4 local sweep
    for (int i = 0; i < 128; i++) begin
      setTx(pat(i, 29), 8'(i * 5)); setRx(pat(i, 41), 8'(i));
      tick();
      macRxIs("R3 loop", pat(i, 29), 8'(i * 5));
      chk("R4 loop", {phyTxCtrl, phyTxData}, {8'(i * 5), pat(i, 29)});
    end

    // R5 PHY frame dropped during loopback
    setTx(IDLE_D, 8'hFF);
    setRx(START_D, 8'h01); tick(); macRxIs("R5 start dropped", IDLE_D, 8'hFF);
    for (int i = 0; i < 6; i++) begin
      setRx(pat(i, 61), 8'h00); tick(); macRxIs("R5 body dropped", IDLE_D, 8'hFF);
    end
    setRx(TERM_D, 8'hFF); tick(); macRxIs("R5 term dropped", IDLE_D, 8'hFF);

    // R8 illegal values ignored
    setRx(pat(3, 71), 8'h00);
    putWrite(4'd0, 32'd2); tick();
    putWrite(4'd0, 32'd3); tick();
    putWrite(4'd0, 32'h0001_0000); tick(); stopWrite();
    setTx(pat(9, 19), 8'h00); tick(); tick();
    readMode("R8 mode kept", 32'd1);
    macRxIs("R8 still loop", pat(9, 19), 8'h00);

    // R9 other address ignored
    putWrite(4'd5, 32'd0); tick(); stopWrite();
    tick(); tick();
    readMode("R9 mode kept", 32'd1);
    macRxIs("R9 still loop", pat(9, 19), 8'h00);
    regAddr = 4'd5; #1;
    chk("R9 other read zero", {40'd0, regRdData}, 72'd0);
    regAddr = 4'd0;

    // R7 leave loopback while MAC frame open
    setRx(pat(1, 23), 8'h00);
    setTx(START_D, 8'h01); tick(); macRxIs("R7 start looped", START_D, 8'h01);
    setTx(pat(0, 17), 8'h00); putWrite(4'd0, 32'd0); tick(); stopWrite();
    macRxIs("R7 body looped", pat(0, 17), 8'h00);
    for (int i = 1; i < 5; i++) begin
      setTx(pat(i, 17), 8'h00); tick();
      macRxIs("R7 body looped", pat(i, 17), 8'h00);
      readMode("R7 mode held", 32'd1);
    end
    setTx(TERM_D, 8'hFF); tick(); macRxIs("R7 term looped", TERM_D, 8'hFF);
    readMode("R7 mode held at end", 32'd1);
    setTx(IDLE_D, 8'hFF); tick();
    macRxIs("R7 after switch", pat(1, 23), 8'h00);
    readMode("R7 switched", 32'd0);

    // R10 enter loopback while PHY frame open
    setTx(pat(2, 43), 8'h00);
    setRx(START_D, 8'h01); tick(); macRxIs("R10 start passed", START_D, 8'h01);
    setRx(pat(0, 31), 8'h00); putWrite(4'd0, 32'd1); tick(); stopWrite();
    macRxIs("R10 body passed", pat(0, 31), 8'h00);
    for (int i = 1; i < 5; i++) begin
      setRx(pat(i, 31), 8'h00); tick();
      macRxIs("R10 body passed", pat(i, 31), 8'h00);
      readMode("R10 mode held", 32'd0);
    end
    setRx(TERM_D, 8'hFF); tick(); macRxIs("R10 term passed", TERM_D, 8'hFF);
    setRx(pat(7, 31), 8'h00); tick();
    macRxIs("R10 after switch", pat(2, 43), 8'h00);
    readMode("R10 switched", 32'd1);

    // R11 request lands right before a MAC frame start
    setTx(IDLE_D, 8'hFF); setRx(IDLE_D, 8'hFF);
    putWrite(4'd0, 32'd0); tick(); stopWrite();
    setTx(START_D, 8'h01); setRx(pat(5, 11), 8'h00); tick();
    macRxIs("R11 start looped", START_D, 8'h01);
    readMode("R11 mode held", 32'd1);
    setTx(pat(4, 13), 8'h00); tick(); macRxIs("R11 body looped", pat(4, 13), 8'h00);
    setTx(TERM_D, 8'hFF); tick(); macRxIs("R11 term looped", TERM_D, 8'hFF);
    setTx(IDLE_D, 8'hFF); tick();
    macRxIs("R11 after switch", pat(5, 11), 8'h00);
    readMode("R11 switched", 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule